// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital heart of a 12-bit successive-approximation analog-to-digital converter. It drives a trial code to an external DAC and reads back a single comparator decision. From these it resolves a straight-binary result, one bit at a time from the most significant bit down. A conversion is launched by a rising edge on a start input that has no timing relation to the conversion clock. The start input is independent of the chip-select and read strobes. While a conversion runs, an active-low busy flag is held low.

The result is offered on a bus that can be turned off. The bus is modelled as a data word plus an output-enable. It is driven only when the converter is idle and both chip-select and read are low. A low-power state is entered when the mode input is low while read is high, and it is left when mode returns high. The first conversion after waking is a dummy run: it flushes the internal state and reports no valid result. Every later conversion sets a result-valid flag.

Top module: `sar_engine`

## Requirements
- R1: After reset, `busyN` is 1, `trialCode` is 0, `dataOe` is 0, `dataOut` is 0, `resultValid` is 0 and `sleepOut` is 0.
- R2: `startIn` passes through a two-flop synchroniser. When it rises and stays high across at least two clock edges, `busyN` goes low after the third rising clock edge that follows the rise. `busyN` then stays low for exactly 28 clock cycles.
- R3: A rising edge of `startIn` that arrives while `busyN` is low, or while `sleepOut` is 1, starts nothing and does not lengthen the running conversion. Starting does not depend on `csN` or `rdN`.
- R4: Inside a conversion, cycles are numbered 0 to 27. Cycle 0 clears `trialCode`. At the end of cycle 2+2*(11-b), bit b of `trialCode` is set. At the end of the following cycle, that bit is cleared if `cmpHigh` is 1, where `cmpHigh` = 1 means the DAC level is above the input. With an ideal comparator, the final code equals the input code.
- R5: `dataOe` is 1 exactly when `csN` is 0, `rdN` is 0 and `busyN` is 1. It is never 1 during a conversion.
- R6: `dataOut` shows the result register while `dataOe` is 1 and is 0 otherwise. The result register loads at the end of conversion cycle 26.
- R7: When the block is idle and a clock edge sees `modeIn` = 0 with `rdN` = 1, `sleepOut` becomes 1. It stays 1 until an edge sees `modeIn` = 1. With `rdN` = 0 the low-power state is not entered. A `modeIn` drop during a conversion takes effect only after the conversion has finished.
- R8: Entering the low-power state clears `resultValid`. The first conversion after leaving it is a dummy: it loads 0 into the result register and leaves `resultValid` at 0. Each later conversion sets `resultValid` in the same cycle that `busyN` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Asynchronous convert-start; a rising edge launches a conversion |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| modeIn | input | 1 | 0 requests the low-power state, 1 is normal operation |
| cmpHigh | input | 1 | Comparator decision: 1 when the DAC level exceeds the input |
| trialCode | output | 12 | Trial code driven to the DAC |
| busyN | output | 1 | Active-low conversion-in-progress flag |
| dataOut | output | 12 | Result bus data (0 when not enabled) |
| dataOe | output | 1 | Result bus output-enable |
| resultValid | output | 1 | The held result comes from a real conversion |
| sleepOut | output | 1 | The block is in the low-power state |

## Verification
The bench drives a cycle model and probes several corner cases:

- **Input codes.** It uses all-zeros, all-ones, the two codes on either side of mid-scale, and a sweep of intermediate values. A decision step that tested or cleared the wrong bit would give a wrong final code at these points.
- **Restart during a conversion.** A second start edge is sent mid-conversion. A design that did not ignore it would stretch or restart busy beyond 28 cycles.
- **Start during low-power state.** A start edge is sent while asleep. A design that did not ignore it would drop busy.
- **Mode drop during a conversion.** `modeIn` falls while busy. A design that acted on it at once would abort the conversion.
- **Dummy run after wake-up.** This run must read back as zero with valid low. A design that skipped the dummy would report a stale or fresh code as valid.
- **Bus while busy.** The bus is probed during busy. A gating error there would show up as a live enable.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Upper bound on the resolution; sizes the bit index carried in the strobes.
  localparam int SAR_MAX_BITS = 16;
  localparam int SAR_IDX_W    = $clog2(SAR_MAX_BITS);

  // Per-cycle commands from the sequencer to the datapath.
  typedef struct packed {
    logic                 clrTrial;  // wipe the trial register
    logic                 setBit;    // raise trial bit bitIdx
    logic                 decide;    // drop trial bit bitIdx if the comparator says too high
    logic                 loadRes;   // copy trial into the result register
    logic                 zeroRes;   // with loadRes: load zero instead (dummy run)
    logic [SAR_IDX_W-1:0] bitIdx;
  } sar_strobe_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 2,
  parameter int LOAD_CYC    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        modeIn,
  input  logic        rdN,
  output sar_strobe_t strb,
  output logic        busyN,
  output logic        resultValid,
  output logic        sleepOut
);
  localparam int TRIAL_CYC = 2 * WIDTH;
  localparam int TOTAL_CYC = SETTLE_CYC + TRIAL_CYC + LOAD_CYC;
  localparam int LOAD_AT   = SETTLE_CYC + TRIAL_CYC;
  localparam int LAST_CYC  = TOTAL_CYC - 1;
  localparam int CNT_W     = $clog2(TOTAL_CYC);

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_SLEEP} state_t;

  state_t               state;
  logic [SYNC_STAGES:0] syncQ;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     phase;
  logic                 dummyPend;
  logic                 startEdge;
  logic                 inTrial;
  logic                 lastCyc;

  // Top bit of syncQ is the history flop used for edge detection.
  assign startEdge = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
  assign lastCyc   = (cnt == CNT_W'(LAST_CYC));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ       <= '0;
      state       <= ST_IDLE;
      cnt         <= '0;
      dummyPend   <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-1:0], startIn};
      case (state)
        ST_IDLE: begin
          if (!modeIn && rdN) begin
            state       <= ST_SLEEP;
            resultValid <= 1'b0;
          end else if (startEdge) begin
            state <= ST_CONV;
            cnt   <= '0;
          end
        end
        ST_CONV: begin
          if (lastCyc) begin
            state       <= ST_IDLE;
            resultValid <= ~dummyPend;
            dummyPend   <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SLEEP: begin
          if (modeIn) begin
            state     <= ST_IDLE;
            dummyPend <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busyN    = (state != ST_CONV);
  assign sleepOut = (state == ST_SLEEP);

  always_comb begin
    phase   = cnt - CNT_W'(SETTLE_CYC);
    inTrial = (state == ST_CONV) && (cnt >= CNT_W'(SETTLE_CYC)) && (cnt < CNT_W'(LOAD_AT));
    strb.clrTrial = (state == ST_CONV) && (cnt == '0);
    strb.setBit   = inTrial && !phase[0];
    strb.decide   = inTrial && phase[0];
    strb.loadRes  = (state == ST_CONV) && (cnt == CNT_W'(LOAD_AT));
    strb.zeroRes  = dummyPend;
    strb.bitIdx   = inTrial ? SAR_IDX_W'(WIDTH - 1 - int'(phase[CNT_W-1:1])) : '0;
  end

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && !lastCyc) |=> !busyN); // R2
  AST_END_ON_TIME: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && lastCyc) |=> busyN); // R2
  AST_NO_WAKE_START: assert property (@(posedge clk) disable iff (!rstN)
    sleepOut |=> busyN); // R3
  AST_SLEEP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepOut) |-> $past(busyN)); // R7
  AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resultValid) |-> $rose(busyN)); // R8
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  sar_strobe_t      strb,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] trialCode,
  output logic [WIDTH-1:0] resultCode
);
  logic [WIDTH-1:0] trialQ;
  logic [WIDTH-1:0] resultQ;

  for (genvar b = 0; b < WIDTH; b++) begin : g_trialBit
    logic hit;
    assign hit = (strb.bitIdx == SAR_IDX_W'(b));
    always_ff @(posedge clk) begin
      if (!rstN)                           trialQ[b] <= 1'b0;
      else if (strb.clrTrial)              trialQ[b] <= 1'b0;
      else if (strb.setBit && hit)         trialQ[b] <= 1'b1;
      else if (strb.decide && hit && cmpHigh) trialQ[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             resultQ <= '0;
    else if (strb.loadRes) resultQ <= strb.zeroRes ? '0 : trialQ;
  end

  assign trialCode  = trialQ;
  assign resultCode = resultQ;

  AST_DECIDE_AFTER_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.decide |-> trialQ[strb.bitIdx]); // R4
  AST_SET_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBit |=> trialQ[$past(strb.bitIdx)]); // R4
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             csN,
  input  logic             rdN,
  input  logic             modeIn,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] trialCode,
  output logic             busyN,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataOe,
  output logic             resultValid,
  output logic             sleepOut
);
  sar_strobe_t      strb;
  logic [WIDTH-1:0] resultCode;

  sar_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .modeIn(modeIn), .rdN(rdN),
    .strb(strb), .busyN(busyN), .resultValid(resultValid), .sleepOut(sleepOut)
  );

  sar_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .resultCode(resultCode)
  );

  assign dataOe  = !csN && !rdN && busyN;
  assign dataOut = dataOe ? resultCode : '0;

  AST_BUS_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !busyN |-> !dataOe); // R5
  AST_SLEEP_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sleepOut |-> busyN); // R7
endmodule

// File: tb/sar_engine_test.sv
module sar_engine_test;
  localparam int W = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, startIn, csN, rdN, modeIn, cmpHigh;
  logic [W-1:0] trialCode, dataOut;
  logic busyN, dataOe, resultValid, sleepOut;
  int inCode;

  // Ideal comparator: high when the DAC code exceeds the input code.
  assign cmpHigh = (int'(trialCode) > inCode);

  sar_engine #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .csN(csN), .rdN(rdN),
    .modeIn(modeIn), .cmpHigh(cmpHigh), .trialCode(trialCode), .busyN(busyN),
    .dataOut(dataOut), .dataOe(dataOe), .resultValid(resultValid), .sleepOut(sleepOut)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit running = 0;

  // Behavioural reference
  int mS1, mS2, mS3, mCnt, mTrial, mResult;
  bit mValid, mSleep, mDummy;

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mS3 = 0; mCnt = -1; mTrial = 0; mResult = 0;
      mValid = 0; mSleep = 0; mDummy = 0;
    end else begin
      automatic bit rise = (mS2 == 1) && (mS3 == 0);
      mS3 = mS2; mS2 = mS1; mS1 = int'(startIn);
      if (mCnt >= 0) begin
        if (mCnt == 0) mTrial = 0;
        if (mCnt >= 2 && mCnt < 26) begin
          automatic int k = mCnt - 2;
          automatic int b = 11 - k / 2;
          if (k % 2 == 0) mTrial = mTrial | (1 << b);
          else if (mTrial > inCode) mTrial = mTrial & ~(1 << b);
        end
        if (mCnt == 26) mResult = mDummy ? 0 : mTrial;
        if (mCnt == 27) begin
          mCnt = -1; mValid = !mDummy; mDummy = 0;
        end else mCnt++;
      end else if (mSleep) begin
        if (modeIn) begin mSleep = 0; mDummy = 1; end
      end else if (!modeIn && rdN) begin
        mSleep = 1; mValid = 0;
      end else if (rise) begin
        mCnt = 0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison, taken mid-low-phase after inputs settle.
  always @(negedge clk) begin
    if (running) begin
      automatic bit expOe;
      #3;
      expOe = !csN && !rdN && (mCnt < 0);
      check("R2 busyN", int'(busyN), (mCnt < 0) ? 1 : 0);
      check("R4 trialCode", int'(trialCode), mTrial);
      check("R5 dataOe", int'(dataOe), int'(expOe));
      check("R6 dataOut", int'(dataOut), expOe ? mResult : 0);
      check("R7 sleepOut", int'(sleepOut), int'(mSleep));
      check("R8 resultValid", int'(resultValid), int'(mValid));
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      mismatched++;
      $display("FAIL R2 watchdog expired actual=%0d expected=<60000", cycles);
      finishRun();
    end
  end

  task automatic convert(input int code, input bit restart, input bit dropMode, input int expLen);
    int lowCount = 0;
    int firstLow = -1;
    @(negedge clk);
    inCode = code;
    startIn = 1'b1;
    for (int i = 1; i <= 45; i++) begin
      @(negedge clk);
      if (!busyN) begin
        lowCount++;
        if (firstLow < 0) firstLow = i;
      end
      if (i == 3) startIn = 1'b0;
      if (restart && i == 10) startIn = 1'b1;
      if (restart && i == 13) startIn = 1'b0;
      if (dropMode && i == 6) modeIn = 1'b0;
    end
    check("R2/R3 busy length", lowCount, expLen);
    if (expLen > 0) check("R2 busy onset cycle", firstLow, 3);
  endtask

  task automatic readBus(input int expData, input bit expValid, input string tag);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0;
    @(negedge clk);
    check({tag, " R5 bus enabled"}, int'(dataOe), 1);
    check({tag, " R6 read data"}, int'(dataOut), expData);
    check({tag, " R8 valid"}, int'(resultValid), int'(expValid));
    csN = 1'b1; rdN = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; startIn = 1'b0; csN = 1'b1; rdN = 1'b1; modeIn = 1'b1; inCode = 0;
    repeat (3) @(negedge clk);
    check("R1 busyN", int'(busyN), 1);
    check("R1 trialCode", int'(trialCode), 0);
    check("R1 dataOe", int'(dataOe), 0);
    check("R1 dataOut", int'(dataOut), 0);
    check("R1 resultValid", int'(resultValid), 0);
    check("R1 sleepOut", int'(sleepOut), 0);
    rstN = 1'b1;
    running = 1;

    // R4: boundary and mid-scale codes
    convert(2730, 0, 0, 28); readBus(2730, 1, "R4 0xAAA");
    convert(0, 0, 0, 28);    readBus(0, 1, "R4 zero");
    convert(4095, 0, 0, 28); readBus(4095, 1, "R4 full");
    convert(2048, 0, 0, 28); readBus(2048, 1, "R4 mid");
    convert(2047, 0, 0, 28); readBus(2047, 1, "R4 below mid");
    for (int k = 0; k < 6; k++) begin
      convert(k * 611 + 29, 0, 0, 28);
      readBus(k * 611 + 29, 1, "R4 sweep");
    end

    // R3: start works with csN/rdN low; bus stays off while busy (R5)
    csN = 1'b0; rdN = 1'b0;
    convert(1234, 0, 0, 28);
    check("R5 bus live after conversion", int'(dataOe), 1);
    check("R6 data after conversion", int'(dataOut), 1234);
    csN = 1'b1; rdN = 1'b1;

    // R5: chip select high keeps bus off
    @(negedge clk); csN = 1'b1; rdN = 1'b0;
    @(negedge clk); check("R5 csN high", int'(dataOe), 0);
    rdN = 1'b1;

    // R3: second start during a conversion is ignored
    convert(3000, 1, 0, 28); readBus(3000, 1, "R3 restart");

    // R7: mode low with read low does not sleep
    @(negedge clk); modeIn = 1'b0; rdN = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 no sleep with rdN low", int'(sleepOut), 0);
    modeIn = 1'b1; rdN = 1'b1;

    // R7/R8: sleep entry, ignored start, wake, dummy run
    @(negedge clk); modeIn = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 sleep entered", int'(sleepOut), 1);
    check("R8 valid cleared on sleep", int'(resultValid), 0);
    convert(500, 0, 0, 0);
    check("R3 still asleep", int'(sleepOut), 1);
    modeIn = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 sleep left", int'(sleepOut), 0);
    convert(777, 0, 0, 28); readBus(0, 0, "R8 dummy");
    convert(777, 0, 0, 28); readBus(777, 1, "R8 after dummy");

    // R7: mode drop mid-conversion waits for the end
    convert(100, 0, 1, 28);
    check("R7 sleep after conversion", int'(sleepOut), 1);
    modeIn = 1'b1;
    repeat (2) @(negedge clk);
    convert(4000, 0, 0, 28); readBus(0, 0, "R8 dummy 2");
    convert(4000, 0, 0, 28); readBus(4000, 1, "R8 valid 2");

    repeat (3) @(negedge clk);
    running = 0;
    finishRun();
  end
endmodule